// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block is the decision core of a single-product vending machine. Each clock it sees at most one coin and keeps the credit collected so far as a multiple of five cents, from zero up to thirty-five. The price is forty cents, and the block never accepts more than fifty cents in total. When a coin brings the credit to the price or a little past it, the block releases the product, returns any change as a single coin and clears the credit. A coin that would push the total past the ceiling is handed straight back, and the credit stays as it was.

The outputs are Mealy outputs. They are formed from the registered credit and the coin on the input in the same cycle. This makes each output a one-cycle pulse that lines up with the coin that caused it. The credit register moves on the next rising edge. The surrounding machine presents coins already validated and takes the outputs as commands to its coin-return and product mechanisms.

Top module: `vend_ctrl`

## Requirements
- R1: A high `rst` sampled at a rising edge sets the credit to zero cents. While `rst` is high, `ret_coin_o` and `dispense_o` are 0 whatever coin is presented.
- R2: Coins use a 2-bit code: 00 is no coin, 01 a nickel (5c), 10 a dime (10c) and 11 a quarter (25c). `ret_coin_o` uses the same code. The credit register holds the credit divided by five, so 000 is 0c, 001 is 5c and 111 is 35c.
- R3: With coin code 00 the credit does not change, and both outputs are 0 in that cycle.
- R4: A coin that leaves credit plus coin below 40c sets the credit to that sum on the next edge, and both outputs stay 0.
- R5: When credit plus coin is exactly 40c, `dispense_o` is 1 and `ret_coin_o` is 00 in that cycle, and the credit becomes 0c on the next edge.
- R6: When credit plus coin is 45c, `dispense_o` is 1 and `ret_coin_o` is 01 (nickel) in that cycle, and the credit becomes 0c.
- R7: When credit plus coin is 50c, `dispense_o` is 1 and `ret_coin_o` is 10 (dime) in that cycle, and the credit becomes 0c.
- R8: When credit plus coin would exceed 50c, `ret_coin_o` equals the coin code, `dispense_o` is 0, and the credit does not change.
- R9: The outputs depend only on the current credit and on the coin in the current cycle, so each one lasts exactly one cycle. In the cycle after a sale or a rejection, with no coin presented, both are 0 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_i | input | 2 | Coin presented this cycle (00 none, 01 nickel, 10 dime, 11 quarter) |
| ret_coin_o | output | 2 | Coin handed back this cycle, same code |
| dispense_o | output | 1 | Release the product this cycle |

## Verification
On every cycle the assertions check several relations between the outputs and the credit register:
- an idle input never changes the credit;
- a sale always clears the credit;
- a rejection returns the coin itself and leaves the credit alone;
- change is never a quarter;
- an accepted coin without a sale always raises the credit.

Only the bench scenarios can show the exact credit arithmetic: that the product appears on the precise coin that reaches forty, that forty-five and fifty cents give the right change coin, and that credit held through idle cycles, rejections and resets adds up correctly in later sales.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Coin code shared by the input and the return output.
    typedef enum logic [1:0] {
        COIN_NONE    = 2'b00,
        COIN_NICKEL  = 2'b01,
        COIN_DIME    = 2'b10,
        COIN_QUARTER = 2'b11
    } coin_e;

    // Amounts are counted in units of five cents.
    localparam int NICKEL_UNITS  = 1;
    localparam int DIME_UNITS    = 2;
    localparam int QUARTER_UNITS = 5;

    localparam int DEF_PRICE_UNITS = 8;   // 40 cents
    localparam int DEF_CAP_UNITS   = 10;  // 50 cents

endpackage

// File: rtl/vend_coin_value.sv
module vend_coin_value
    import vend_pkg::*;
#(
    parameter int SUM_W = 4
) (
    input  logic [1:0]       coin_i,
    output logic [SUM_W-1:0] units_o
);

    always_comb begin
        unique case (coin_i)
            COIN_NICKEL:  units_o = SUM_W'(NICKEL_UNITS);
            COIN_DIME:    units_o = SUM_W'(DIME_UNITS);
            COIN_QUARTER: units_o = SUM_W'(QUARTER_UNITS);
            default:      units_o = '0;
        endcase
    end

endmodule

// File: rtl/vend_settle.sv
module vend_settle
    import vend_pkg::*;
#(
    parameter int CREDIT_W    = 3,
    parameter int SUM_W       = 4,
    parameter int PRICE_UNITS = 8,
    parameter int CAP_UNITS   = 10
) (
    input  logic [CREDIT_W-1:0] credit_i,
    input  logic [1:0]          coin_i,
    input  logic [SUM_W-1:0]    coin_units_i,
    output logic [CREDIT_W-1:0] credit_o,
    output logic [1:0]          ret_o,
    output logic                give_o
);

    localparam logic [SUM_W-1:0] PRICE_S = SUM_W'(PRICE_UNITS);
    localparam logic [SUM_W-1:0] CAP_S   = SUM_W'(CAP_UNITS);

    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] excess;

    // Change is one coin: a nickel for one unit over, a dime for two.
    function automatic logic [1:0] change_coin(input logic [SUM_W-1:0] over);
        logic [1:0] code;
        if (over == SUM_W'(NICKEL_UNITS))
            code = COIN_NICKEL;
        else if (over == SUM_W'(DIME_UNITS))
            code = COIN_DIME;
        else
            code = COIN_NONE;
        return code;
    endfunction

    assign total  = SUM_W'(credit_i) + coin_units_i;
    assign excess = total - PRICE_S;

    always_comb begin
        credit_o = credit_i;
        ret_o    = COIN_NONE;
        give_o   = 1'b0;
        if (coin_i != COIN_NONE) begin
            if (total > CAP_S) begin
                ret_o = coin_i;
            end else if (total >= PRICE_S) begin
                credit_o = '0;
                give_o   = 1'b1;
                ret_o    = change_coin(excess);
            end else begin
                credit_o = total[CREDIT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int PRICE_UNITS = DEF_PRICE_UNITS,
    parameter int CAP_UNITS   = DEF_CAP_UNITS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] coin_i,
    output logic [1:0] ret_coin_o,
    output logic       dispense_o
);

    localparam int CREDIT_W = $clog2(PRICE_UNITS);
    localparam int SUM_W    = $clog2(PRICE_UNITS + QUARTER_UNITS + 1);

    typedef struct packed {
        logic [CREDIT_W-1:0] credit;
    } vend_state_t;

    vend_state_t         state_d, state_q;
    logic [SUM_W-1:0]    coin_units;
    logic [CREDIT_W-1:0] settle_credit;
    logic [1:0]          settle_ret;
    logic                settle_give;
    logic [CREDIT_W-1:0] credit_q;

    vend_coin_value #(.SUM_W(SUM_W)) u_value (
        .coin_i  (coin_i),
        .units_o (coin_units)
    );

    vend_settle #(
        .CREDIT_W    (CREDIT_W),
        .SUM_W       (SUM_W),
        .PRICE_UNITS (PRICE_UNITS),
        .CAP_UNITS   (CAP_UNITS)
    ) u_settle (
        .credit_i     (state_q.credit),
        .coin_i       (coin_i),
        .coin_units_i (coin_units),
        .credit_o     (settle_credit),
        .ret_o        (settle_ret),
        .give_o       (settle_give)
    );

    always_comb begin
        state_d.credit = settle_credit;
        ret_coin_o     = settle_ret;
        dispense_o     = settle_give;
        if (rst) begin
            state_d.credit = '0;
            ret_coin_o     = COIN_NONE;
            dispense_o     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign credit_q = state_q.credit;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
    parameter int CREDIT_W = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          coin_i,
    input logic [1:0]          ret_coin_o,
    input logic                dispense_o,
    input logic [CREDIT_W-1:0] credit_q
);

    // R1: reset clears the credit and silences the outputs
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> credit_q == '0);
    a_r1_reset_quiet:  assert property (@(posedge clk) rst |-> (ret_coin_o == 2'b00 && !dispense_o));

    // R3: an idle input keeps the credit and drives nothing
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        coin_i == 2'b00 |-> (ret_coin_o == 2'b00 && !dispense_o));
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        coin_i == 2'b00 |=> $stable(credit_q));

    // R4: a coin that is accepted without a sale raises the credit
    a_r4_credit_grows: assert property (@(posedge clk) disable iff (rst)
        (coin_i != 2'b00 && !dispense_o && ret_coin_o == 2'b00) |=> credit_q > $past(credit_q));

    // R5: every sale clears the credit
    a_r5_sale_clears: assert property (@(posedge clk) disable iff (rst)
        dispense_o |=> credit_q == '0);

    // R6 / R7: change is a nickel or a dime, never a quarter
    a_r6_change_coin: assert property (@(posedge clk) disable iff (rst)
        (dispense_o && ret_coin_o != 2'b00) |-> (ret_coin_o == 2'b01 || ret_coin_o == 2'b10));

    // R8: a rejection returns the same coin and leaves the credit alone
    a_r8_reject_same: assert property (@(posedge clk) disable iff (rst)
        (!dispense_o && ret_coin_o != 2'b00) |-> ret_coin_o == coin_i);
    a_r8_reject_hold: assert property (@(posedge clk) disable iff (rst)
        (!dispense_o && ret_coin_o != 2'b00) |=> $stable(credit_q));

endmodule

bind vend_ctrl vend_ctrl_chk #(.CREDIT_W(CREDIT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .coin_i     (coin_i),
    .ret_coin_o (ret_coin_o),
    .dispense_o (dispense_o),
    .credit_q   (credit_q)
);

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/100ps
module tb_vend_ctrl;

    localparam logic [1:0] NONE = 2'b00, NIC = 2'b01, DIM = 2'b10, QTR = 2'b11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] coin_i = NONE;
    logic [1:0] ret_coin_o;
    logic       dispense_o;

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    vend_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .coin_i     (coin_i),
        .ret_coin_o (ret_coin_o),
        .dispense_o (dispense_o)
    );

    // Present a coin after a falling edge, check the Mealy outputs, then let the rising edge take it.
    task automatic put(input logic [1:0] c, input logic [1:0] exp_ret, input logic exp_p,
                       input string req);
        @(negedge clk);
        coin_i = c;
        #1;
        n_run++;
        if (ret_coin_o !== exp_ret || dispense_o !== exp_p) begin
            n_fail++;
            $display("FAIL %s: coin=%b got ret=%b p=%b expected ret=%b p=%b",
                     req, c, ret_coin_o, dispense_o, exp_ret, exp_p);
        end
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        coin_i = NONE;
    endtask

    // R1: outputs silent during reset, credit cleared by reset
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        coin_i = QTR;
        #1;
        n_run++;
        if (ret_coin_o !== NONE || dispense_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: reset outputs got ret=%b p=%b expected ret=00 p=0", ret_coin_o, dispense_o);
        end
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        coin_i = NONE;
        put(DIM, NONE, 1'b0, "R1");
        put(DIM, NONE, 1'b0, "R1");
        put(DIM, NONE, 1'b0, "R1");
        put(DIM, NONE, 1'b1, "R1");
        // mid-credit reset: 30c then reset, then 40c needed again
        put(QTR, NONE, 1'b0, "R1");
        put(NIC, NONE, 1'b0, "R1");
        do_reset();
        put(QTR, NONE, 1'b0, "R1");
        put(DIM, NONE, 1'b0, "R1");
        put(NIC, NONE, 1'b1, "R1");
    endtask

    // R3 and R9: idle holds credit, outputs drop right after a sale
    task automatic t_idle();
        put(NIC, NONE, 1'b0, "R3");
        put(NONE, NONE, 1'b0, "R3");
        put(NONE, NONE, 1'b0, "R3");
        put(QTR, NONE, 1'b0, "R3");
        put(DIM, NONE, 1'b1, "R3");
        put(NONE, NONE, 1'b0, "R9");
    endtask

    // R4 and R2: nickels walk the credit up to 35c; R5 on the eighth
    task automatic t_accumulate();
        for (int i = 0; i < 7; i++) put(NIC, NONE, 1'b0, "R4");
        put(NIC, NONE, 1'b1, "R5");
        put(DIM, NONE, 1'b0, "R4");
        put(QTR, NONE, 1'b0, "R4");
        put(NIC, NONE, 1'b1, "R5");
    endtask

    // R6: 45c gives a nickel back; credit cleared afterwards
    task automatic t_nickel_change();
        put(DIM, NONE, 1'b0, "R6");
        put(DIM, NONE, 1'b0, "R6");
        put(QTR, NIC, 1'b1, "R6");
        put(NONE, NONE, 1'b0, "R9");
        put(QTR, NONE, 1'b0, "R6");
        put(DIM, NONE, 1'b0, "R6");
        put(DIM, NIC, 1'b1, "R6");
    endtask

    // R7: 50c gives a dime back
    task automatic t_dime_change();
        put(QTR, NONE, 1'b0, "R7");
        put(QTR, DIM, 1'b1, "R7");
        put(QTR, NONE, 1'b0, "R7");
        put(NIC, NONE, 1'b0, "R7");
        put(DIM, NONE, 1'b1, "R7");
    endtask

    // R8: over-ceiling coin returned, credit kept
    task automatic t_reject();
        put(DIM, NONE, 1'b0, "R8");
        put(DIM, NONE, 1'b0, "R8");
        put(DIM, NONE, 1'b0, "R8");
        put(QTR, QTR, 1'b0, "R8");
        put(QTR, QTR, 1'b0, "R8");
        put(NONE, NONE, 1'b0, "R9");
        put(DIM, NONE, 1'b1, "R8");
        for (int i = 0; i < 7; i++) put(NIC, NONE, 1'b0, "R8");
        put(QTR, QTR, 1'b0, "R8");
        put(DIM, NIC, 1'b1, "R8");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_idle();
        t_accumulate();
        t_nickel_change();
        t_dime_change();
        t_reject();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule